// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing slave engine of a two-wire serial memory. It oversamples the raw SCL and SDA lines on the system clock and finds clock edges and start and stop conditions. It drives the shared data line only through an open-drain enable that pulls it low. When a device address word arrives that carries the fixed `1010` type prefix and the three strap bits, the slave acknowledges on the ninth clock, unless the internal write cycle is still running. During that cycle it stays silent, so a master can poll until the write finishes.

After the address phase, the block takes two word-address bytes and then data bytes for a byte or page write, or it sends bytes for current-address, random and sequential reads. It does not hold the word-address counter, the page buffer or the array. It reports to them through single-cycle strobes: load the address, push a data byte, commit on stop, and advance after a read byte is taken. It reads the byte at the current address from a data input.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset, `sda_oe` is low and no strobe (`waddr_ld`, `wbyte_stb`, `commit_stb`, `rd_adv`) is asserted.
- R2: A start condition (SDA falling while SCL is high) in any state abandons the current transfer and begins a new device-address reception. Data bytes received before that start are never committed.
- R3: A device word sent MSB first as `1,0,1,0,S2,S1,S0,RW` with `S2..S0` equal to `strap_i[2:0]` is acknowledged by a low on the ninth clock. Any other word gets no acknowledge, and the slave leaves SDA released until the next start.
- R4: While `busy_i` is high at the falling edge that ends the eighth bit, the device word is not acknowledged.
- R5: In a write (RW=0), the two bytes after the device word are each acknowledged. `waddr_ld` pulses once with `waddr_o` = {low ADDR_W-8 bits of the first byte, second byte}. Upper bits of the first byte are dropped.
- R6: Each later byte is sampled MSB first on SCL rising edges, acknowledged, and presented on `wbyte_o` with a one-cycle `wbyte_stb`.
- R7: `commit_stb` pulses once on a stop condition only if at least one data byte arrived since the last start. An address-only write followed by a stop or a repeated start does not commit.
- R8: In a read (RW=1), the slave sends `rd_data_i` MSB first, pulses `rd_adv` when the byte is taken, and changes SDA only after SCL falling edges.
- R9: After each read byte, a master acknowledge (0) starts the next byte with another `rd_adv`. A master non-acknowledge makes the slave release SDA and stay silent until the next start or stop.
- R10: A start, nine clocks with SDA released, a second start and a stop leave the slave idle and without driving SDA, and the next valid device word is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (resolved bus level) |
| sda_oe | output | 1 | Pull SDA low when high; released otherwise |
| strap_i | input | 3 | Device select straps compared with address bits 3..1 |
| busy_i | input | 1 | Internal write cycle in progress |
| rd_data_i | input | 8 | Byte at the current word address |
| waddr_ld | output | 1 | Load strobe for the word-address counter |
| waddr_o | output | ADDR_W | Word address to load |
| wbyte_stb | output | 1 | Push strobe for the page write buffer |
| wbyte_o | output | 8 | Received data byte |
| commit_stb | output | 1 | Start the internal write cycle |
| rd_adv | output | 1 | Advance the address counter after a read byte is taken |

## Verification
The bench builds the block with ADDR_W=15 and a two-stage synchronizer. That makes the first address byte carry one bit that must be dropped, and it places slave SDA updates about three system clocks after an SCL edge. SCL runs at one sixteenth of the system clock, so each ninth-clock acknowledge and each read bit must appear within the low half-period, and a late update would be caught. An environment model of the address counter, memory and busy timer lets the bench check write-then-read round trips, busy polling and sequential reads against values it predicts itself.

// File: rtl/tw_pkg.sv
// Shared types for the two-wire memory slave.
package tw_pkg;
    // Bus-level phase of the transfer engine
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_st_e;

    // Meaning of the byte being received or acknowledged
    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DAT
    } rx_kind_e;
endpackage

// File: rtl/tw_line_sync.sv
// Synchronizes raw SCL/SDA into the system clock domain and detects
// SCL edges plus start/stop conditions. Assumes clk >= 8x SCL and
// STAGES >= 2. Lines reset to the idle-high level so reset makes no edge.
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Metastability chains, then one more flop to compare against
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_q;
            sda_d    <= sda_q;
        end
    end

    assign scl_q = scl_pipe[STAGES-1];
    assign sda_q = sda_pipe[STAGES-1];

    // Edge and condition decode on the synchronized samples
    always_comb begin
        scl_rise  = scl_q & ~scl_d;
        scl_fall  = ~scl_q & scl_d;
        start_det = scl_q & scl_d & sda_d & ~sda_q;
        stop_det  = scl_q & scl_d & ~sda_d & sda_q;
    end
endmodule

// File: rtl/tw_dev_match.sv
// Compares a received device word with the fixed type prefix and the
// strap inputs. Bit 0 (read/write) is not part of the match.
module tw_dev_match #(
    parameter logic [3:0] PREFIX = 4'b1010
) (
    input  logic [7:0] dev_word,
    input  logic [2:0] strap_i,
    output logic       hit
);
    // Prefix in bits 7..4, straps in bits 3..1
    always_comb hit = (dev_word[7:4] == PREFIX) && (dev_word[3:1] == strap_i);
endmodule

// File: rtl/tw_xfer_fsm.sv
// Byte-level transfer engine: receives device, address and data bytes,
// drives acknowledges and read data, and issues strobes to the external
// address counter and page buffer. Assumes ADDR_W > 8 and edge pulses
// lasting one system clock.
module tw_xfer_fsm
    import tw_pkg::*;
#(
    parameter int         ADDR_W = 15,
    parameter logic [3:0] PREFIX = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [7:0]        rd_data_i,
    output logic              sda_oe,
    output logic              dev_slot,
    output logic              waddr_ld,
    output logic [ADDR_W-1:0] waddr_o,
    output logic              wbyte_stb,
    output logic [7:0]        wbyte_o,
    output logic              commit_stb,
    output logic              rd_adv
);
    localparam int HI_W = ADDR_W - 8;

    bus_st_e         st;
    rx_kind_e        kind;
    logic [2:0]      cnt;
    logic [7:0]      sh;
    logic [HI_W-1:0] hi;
    logic            rw, phase, ack_on, mack, wrote, hit;
    logic [7:0]      byte_nx;

    assign byte_nx = {sh[6:0], sda_q};

    tw_dev_match #(.PREFIX(PREFIX)) u_match (
        .dev_word(byte_nx),
        .strap_i (strap_i),
        .hit     (hit)
    );

    // Main sequencer: start/stop override, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; kind <= K_DEV; cnt <= '0; sh <= '0; hi <= '0;
            rw <= 1'b0; phase <= 1'b0; ack_on <= 1'b0; mack <= 1'b0; wrote <= 1'b0;
            waddr_ld <= 1'b0; waddr_o <= '0; wbyte_stb <= 1'b0; wbyte_o <= '0;
            commit_stb <= 1'b0; rd_adv <= 1'b0;
        end else begin
            waddr_ld   <= 1'b0;
            wbyte_stb  <= 1'b0;
            commit_stb <= 1'b0;
            rd_adv     <= 1'b0;
            if (start_det) begin
                st <= ST_RX; kind <= K_DEV; cnt <= '0;
                ack_on <= 1'b0; phase <= 1'b0; wrote <= 1'b0;
            end else if (stop_det) begin
                st <= ST_IDLE; ack_on <= 1'b0; commit_stb <= wrote; wrote <= 1'b0;
            end else begin
                case (st)
                    ST_RX: if (scl_rise) begin
                        sh  <= byte_nx;
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            phase <= 1'b0;
                            st    <= ST_ACK;
                            case (kind)
                                K_DEV: begin
                                    rw <= sda_q;
                                    if (!hit) st <= ST_IDLE;
                                end
                                K_AHI: hi <= byte_nx[HI_W-1:0];
                                K_ALO: begin
                                    waddr_ld <= 1'b1;
                                    waddr_o  <= {hi, byte_nx};
                                end
                                default: begin
                                    wbyte_stb <= 1'b1;
                                    wbyte_o   <= byte_nx;
                                    wrote     <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!phase) begin
                            phase <= 1'b1;
                            if (kind == K_DEV && busy_i) st <= ST_IDLE;
                            else ack_on <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            phase  <= 1'b0;
                            st     <= ST_RX;
                            case (kind)
                                K_DEV: if (rw) begin
                                    sh <= rd_data_i; rd_adv <= 1'b1; st <= ST_TX;
                                end else kind <= K_AHI;
                                K_AHI:   kind <= K_ALO;
                                default: kind <= K_DAT;
                            endcase
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (cnt == 3'd7) begin
                            cnt <= '0;
                            st  <= ST_MACK;
                        end else begin
                            cnt <= cnt + 3'd1;
                            sh  <= {sh[6:0], 1'b0};
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) mack <= ~sda_q;
                        if (scl_fall) begin
                            if (mack) begin
                                sh <= rd_data_i; rd_adv <= 1'b1; st <= ST_TX;
                            end else st <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Open-drain enable: acknowledge slot or a zero read bit
    always_comb begin
        sda_oe   = ack_on | ((st == ST_TX) & ~sh[7]);
        dev_slot = (st == ST_ACK) && (kind == K_DEV);
    end
endmodule

// File: rtl/tw_mem_slave.sv
// Top of the two-wire memory slave: line synchronizer plus transfer
// engine. The address counter, page buffer and array live outside and
// follow the strobes. Assumes clk runs at least 8x SCL.
module tw_mem_slave #(
    parameter int         ADDR_W      = 15,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [7:0]        rd_data_i,
    output logic              waddr_ld,
    output logic [ADDR_W-1:0] waddr_o,
    output logic              wbyte_stb,
    output logic [7:0]        wbyte_o,
    output logic              commit_stb,
    output logic              rd_adv
);
    logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det, dev_slot;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    tw_xfer_fsm #(.ADDR_W(ADDR_W), .PREFIX(DEV_PREFIX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_i   (strap_i),
        .busy_i    (busy_i),
        .rd_data_i (rd_data_i),
        .sda_oe    (sda_oe),
        .dev_slot  (dev_slot),
        .waddr_ld  (waddr_ld),
        .waddr_o   (waddr_o),
        .wbyte_stb (wbyte_stb),
        .wbyte_o   (wbyte_o),
        .commit_stb(commit_stb),
        .rd_adv    (rd_adv)
    );
endmodule

// File: rtl/tw_mem_slave_chk.sv
// Protocol checker for tw_mem_slave, attached with bind below.
module tw_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_q,
    input logic scl_rise,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic dev_slot,
    input logic busy_i,
    input logic sda_oe,
    input logic waddr_ld,
    input logic wbyte_stb,
    input logic commit_stb,
    input logic rd_adv
);
    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({waddr_ld, wbyte_stb, commit_stb, rd_adv}));

    // R4
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && dev_slot) |-> !$past(busy_i));

    // R5
    addr_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waddr_ld |-> $past(scl_rise));

    // R6
    data_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wbyte_stb |-> $past(scl_rise));

    // R7
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> $past(stop_det));

    // R8
    sda_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R9
    adv_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |-> $past(scl_fall));
endmodule

bind tw_mem_slave tw_mem_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_q     (scl_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_slot  (dev_slot),
    .busy_i    (busy_i),
    .sda_oe    (sda_oe),
    .waddr_ld  (waddr_ld),
    .wbyte_stb (wbyte_stb),
    .commit_stb(commit_stb),
    .rd_adv    (rd_adv)
);

// File: tb/tw_mem_slave_tb_top.sv
// Directed bench: a bit-level bus master, plus a model of the address
// counter, memory and busy timer around the slave.
module tw_mem_slave_tb_top;
    localparam int CLK_P  = 10;
    localparam int Q      = 4;      // quarter SCL period in system clocks
    localparam int AW     = 15;
    localparam int BUSY_N = 400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic [2:0]    strap = 3'b101;
    logic          busy;
    logic [7:0]    rd_data;
    logic          sda_oe, waddr_ld, wbyte_stb, commit_stb, rd_adv;
    logic [AW-1:0] waddr;
    logic [7:0]    wbyte;
    logic          bus_sda;

    logic [7:0]    mem [256];
    logic [AW-1:0] cur;
    int            busy_cnt, n_wld, n_wb, n_commit, n_adv;
    logic [AW-1:0] last_waddr;
    logic [7:0]    wlog [4];
    int            checks = 0, errors = 0;
    logic          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign bus_sda = sda_m & ~sda_oe;
    assign busy    = (busy_cnt != 0);
    assign rd_data = mem[cur[7:0]];

    tw_mem_slave #(.ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda), .sda_oe(sda_oe),
        .strap_i(strap), .busy_i(busy), .rd_data_i(rd_data),
        .waddr_ld(waddr_ld), .waddr_o(waddr), .wbyte_stb(wbyte_stb), .wbyte_o(wbyte),
        .commit_stb(commit_stb), .rd_adv(rd_adv)
    );

    // Environment model: counter with in-page wrap on writes, memory, busy timer
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
            cur <= '0; busy_cnt <= 0; n_wld <= 0; n_wb <= 0; n_commit <= 0; n_adv <= 0;
            last_waddr <= '0;
        end else begin
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (waddr_ld) begin cur <= waddr; last_waddr <= waddr; n_wld <= n_wld + 1; end
            if (wbyte_stb) begin
                mem[cur[7:0]] <= wbyte;
                wlog[n_wb % 4] <= wbyte;
                n_wb <= n_wb + 1;
                cur  <= {cur[AW-1:6], cur[5:0] + 6'd1};
            end
            if (rd_adv) begin cur <= cur + 1'b1; n_adv <= n_adv + 1; end
            if (commit_stb) begin busy_cnt <= BUSY_N; n_commit <= n_commit + 1; end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        sda_m = b; wq();
        scl = 1'b1; wq();
        seen = bus_sda; wq();
        scl = 1'b0; wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, ack);
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin bit_io(1'b1, s); d = {d[6:0], s}; end
        bit_io(~m_ack, s);
    endtask

    task automatic t_reset();
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 strobes", int'({waddr_ld, wbyte_stb, commit_stb, rd_adv}), 0);
    endtask

    task automatic t_write();
        logic a;
        bus_start();
        send_byte(8'hAA, a); check("R3 dev ack", int'(a), 0);
        send_byte(8'h92, a); check("R5 hi ack", int'(a), 0);
        send_byte(8'h34, a); check("R5 lo ack", int'(a), 0);
        check("R5 waddr", int'(last_waddr), 'h1234);
        send_byte(8'h5A, a); check("R6 d0 ack", int'(a), 0);
        send_byte(8'hC3, a); check("R6 d1 ack", int'(a), 0);
        check("R6 bytes", int'({wlog[0], wlog[1]}), 'h5AC3);
        bus_stop();
        check("R7 commit", n_commit, 1);
    endtask

    task automatic t_busy();
        logic a;
        bus_start();
        send_byte(8'hAA, a); check("R4 nack busy", int'(a), 1);
        bus_stop();
        repeat (BUSY_N + 50) @(negedge clk);
        bus_start();
        send_byte(8'hAA, a); check("R4 ack idle", int'(a), 0);
        bus_stop();
        check("R7 no commit", n_commit, 1);
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte(8'hA2, a); check("R3 strap nack", int'(a), 1);
        send_byte(8'h00, a); check("R3 silent", int'(a), 1);
        bus_stop();
        strap = 3'b010;
        bus_start();
        send_byte(8'hA4, a); check("R3 other strap", int'(a), 0);
        bus_stop();
        strap = 3'b101;
    endtask

    task automatic t_rand_read();
        logic a; logic [7:0] d; int adv0;
        adv0 = n_adv;
        bus_start();
        send_byte(8'hAA, a); send_byte(8'h12, a); send_byte(8'h34, a);
        bus_start();
        send_byte(8'hAB, a); check("R8 rd dev ack", int'(a), 0);
        recv_byte(1'b0, d); check("R8 rand data", int'(d), 'h5A);
        bus_stop();
        check("R8 adv", n_adv - adv0, 1);
        check("R7 dummy write", n_commit, 1);
    endtask

    task automatic t_seq_read();
        logic a; logic [7:0] d; int adv0;
        adv0 = n_adv;
        bus_start();
        send_byte(8'hAB, a); check("R9 cur dev ack", int'(a), 0);
        recv_byte(1'b1, d); check("R9 byte0", int'(d), 'hC3);
        recv_byte(1'b0, d); check("R9 byte1", int'(d), 'h36 ^ 'h3C);
        recv_byte(1'b0, d); check("R9 silent after nack", int'(d), 'hFF);
        bus_stop();
        check("R9 adv", n_adv - adv0, 2);
    endtask

    task automatic t_abort();
        logic a, s; logic [7:0] d; int w0;
        w0 = n_wld;
        bus_start();
        send_byte(8'hAA, a); send_byte(8'h12, a);
        for (int i = 0; i < 4; i++) bit_io(1'b0, s);
        bus_start();
        send_byte(8'hAB, a); check("R2 restart ack", int'(a), 0);
        recv_byte(1'b0, d); check("R2 data", int'(d), 'h37 ^ 'h3C);
        bus_stop();
        check("R2 no addr load", n_wld - w0, 0);
        bus_start();
        send_byte(8'hAA, a); send_byte(8'h00, a); send_byte(8'h40, a);
        send_byte(8'h77, a);
        bus_start();
        bus_stop();
        check("R2 discard", n_commit, 1);
    endtask

    task automatic t_swreset();
        logic s, a; int ones;
        ones = 0;
        bus_start();
        for (int i = 0; i < 9; i++) begin bit_io(1'b1, s); ones += int'(s); end
        check("R10 quiet clocks", ones, 9);
        bus_start();
        bus_stop();
        check("R10 released", int'(sda_oe), 0);
        bus_start();
        send_byte(8'hAA, a); check("R10 ready", int'(a), 0);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_busy();
        t_mismatch();
        t_rand_read();
        t_seq_read();
        t_abort();
        t_swreset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule